// File: doc/BRIEF.md
# Scan-Port Linker Test Register Set

This block holds the test access logic of a scan-port linker. It contains the 16-state test access port controller, an 8-bit instruction register, and three data registers. The first data register is a per-port select register with two bits for each local port. The second is a 4-bit identification register. The third is a 1-bit bypass stage. Serial data enters on `tdi_i` and leaves on `tdo_o`. The held select value goes out on `sel_o` to the port router, which sits outside this block.

A host uses the block in three steps. It loads an opcode through an instruction scan. It then shifts a data word through the register that the opcode picks. The register applies the word when the controller passes the update state. Two opcodes reach the identification register. One of them reloads it from the `idn_i` pins before the shift. The other leaves the register as it was, so the bits shifted in earlier come back out. Entering Test-Logic-Reset by any path clears the select word and disconnects every local port.

Top module: `jlr_top`

## Requirements
- R1: The controller follows the standard 16-state transition graph. It advances on the rising edge of `tck_i` under `tms_i`. Five cycles with `tms_i` high reach Test-Logic-Reset from any state. Asserting `rst_ni` low forces Test-Logic-Reset at once.
- R2: In Capture-IR the instruction shift stage loads binary 00000001. Every register shifts LSB first: the LSB sits nearest `tdo_o` and the MSB nearest `tdi_i`.
- R3: The active instruction resets to 0xFF, which selects bypass. Any opcode other than 0xFC, 0x7D and 0x7E selects the 1-bit bypass stage. That stage captures 0, so the output is the input delayed by one shift.
- R4: Under opcode 0xFC the identification register loads `idn_i` on the rising edge in Capture-DR, and then shifts out 4 bits.
- R5: Under opcode 0x7D, Capture-DR leaves the identification register unchanged. A scan therefore returns the bits left in it by the previous scan.
- R6: Under opcode 0x7E the data path is the 2*NUM_PORTS-bit select shift stage. Capture-DR loads that stage with the held select value. Bits 2k+1 (enable) and 2k (mode) of `sel_o` belong to local port k, counting from 0.
- R7: `sel_o` changes only on the falling edge of `tck_i` in Update-DR or in Test-Logic-Reset. It stays steady while a new value is being shifted.
- R8: Every falling edge of `tck_i` spent in Test-Logic-Reset clears `sel_o` to zero and sets the active instruction back to bypass.
- R9: `rst_ni` low clears `sel_o` and disables `tdo_o` asynchronously, without a clock edge.
- R10: `tdo_o` and `tdo_oe_o` change on the falling edge of `tck_i`. `tdo_oe_o` is 1 only while the controller is in Shift-IR or Shift-DR; at all other times the output counts as high-impedance.
- R11: A newly shifted opcode takes effect on the falling edge of `tck_i` in Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select that steers the controller |
| tdi_i | input | 1 | Serial data in |
| idn_i | input | 4 | Identification value captured under the preload opcode |
| tdo_o | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe_o | output | 1 | Output enable for `tdo_o`; 0 means high-impedance |
| sel_o | output | 8 | Held select word sent to the port router |

## Verification
Two cases are hard to reach from the ports. The first is the non-preloading identification read. It only shows anything if an earlier scan left a known pattern in the register and the `idn_i` pins are then changed to a different value. The bench does exactly that and expects the old pattern back. The second is the select hold rule. The bench samples `sel_o` on every shift cycle and again in Exit1-DR while a different word is moving through the shift stage. It also drives the controller into Test-Logic-Reset with `tms_i` alone, and separately pulses `rst_ni` between clock edges.

// File: rtl/jlr_pkg.sv
package jlr_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_SEL} dr_path_e;

  localparam logic [IR_W-1:0] OP_ID_LOAD = 8'hFC;
  localparam logic [IR_W-1:0] OP_ID_KEEP = 8'h7D;
  localparam logic [IR_W-1:0] OP_SEL     = 8'h7E;
  localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  function automatic dr_path_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_ID_LOAD, OP_ID_KEEP: return DR_ID;
      OP_SEL:                 return DR_SEL;
      default:                return DR_BYP;
    endcase
  endfunction
endpackage

// File: rtl/jlr_tap.sv
module jlr_tap
  import jlr_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  state_d = tms_i ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  state_d = tms_i ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> state_q == ST_TLR);
  // R1
  upd_exit_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q inside {ST_UPD_DR, ST_UPD_IR} && !tms_i) |=> state_q == ST_RTI);
endmodule

// File: rtl/jlr_ir.sv
module jlr_ir
  import jlr_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       ir_lsb_o,
  output dr_path_e   path_o,
  output logic       id_load_o
);
  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] op_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR) sh_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)  sh_q <= {tdi_i, sh_q[IR_W-1:1]};
  end

  // active opcode moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= OP_BYPASS;
    else if (state_i == ST_TLR)    op_q <= OP_BYPASS;
    else if (state_i == ST_UPD_IR) op_q <= sh_q;
  end

  assign ir_lsb_o  = sh_q[0];
  assign path_o    = decode_op(op_q);
  assign id_load_o = (op_q == OP_ID_LOAD);

  // R2
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> sh_q == IR_CAPTURE);
  // R11
  op_stable_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {ST_UPD_IR, ST_TLR}) |-> $stable(op_q));
endmodule

// File: rtl/jlr_dr.sv
module jlr_dr
  import jlr_pkg::*;
#(
  parameter int SEL_W = 8,
  parameter int ID_W  = 4
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  tap_state_e       state_i,
  input  dr_path_e         path_i,
  input  logic             id_load_i,
  input  logic [ID_W-1:0]  idn_i,
  output logic             dr_lsb_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [ID_W-1:0]  id_q;
  logic [SEL_W-1:0] sel_sh_q;
  logic [SEL_W-1:0] sel_q;
  logic             byp_q;
  logic             cap, sh;

  assign cap = (state_i == ST_CAP_DR);
  assign sh  = (state_i == ST_SH_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= '0;
    else if (path_i == DR_ID) begin
      if (cap && id_load_i) id_q <= idn_i;
      else if (sh)          id_q <= {tdi_i, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sel_sh_q <= '0;
    else if (path_i == DR_SEL) begin
      if (cap)     sel_sh_q <= sel_q;
      else if (sh) sel_sh_q <= {tdi_i, sel_sh_q[SEL_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) byp_q <= 1'b0;
    else if (path_i == DR_BYP) begin
      if (cap)     byp_q <= 1'b0;
      else if (sh) byp_q <= tdi_i;
    end
  end

  // hold stage: routing changes only at update or reset
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (state_i == ST_TLR) sel_q <= '0;
    else if (state_i == ST_UPD_DR && path_i == DR_SEL) sel_q <= sel_sh_q;
  end

  always_comb begin
    unique case (path_i)
      DR_ID:   dr_lsb_o = id_q[0];
      DR_SEL:  dr_lsb_o = sel_sh_q[0];
      default: dr_lsb_o = byp_q;
    endcase
  end

  assign sel_o = sel_q;

  // R4
  id_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && path_i == DR_ID && id_load_i) |=> id_q == $past(idn_i));
  // R5
  id_keep_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && path_i == DR_ID && !id_load_i) |=> $stable(id_q));
  // R7
  sel_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {ST_UPD_DR, ST_TLR}) |-> $stable(sel_q));
  // R8
  sel_tlr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR) |-> sel_q == '0);
endmodule

// File: rtl/jlr_top.sv
module jlr_top
  import jlr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ID_W      = 4,
  localparam int SEL_W    = 2 * NUM_PORTS
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  input  logic [ID_W-1:0]  idn_i,
  output logic             tdo_o,
  output logic             tdo_oe_o,
  output logic [SEL_W-1:0] sel_o
);
  tap_state_e state;
  dr_path_e   path;
  logic       ir_lsb, dr_lsb, id_load;
  logic       tdo_q, oe_q;

  jlr_tap u_tap (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .state_o(state)
  );

  jlr_ir u_ir (
    .tck_i(tck_i), .rst_ni(rst_ni), .tdi_i(tdi_i), .state_i(state),
    .ir_lsb_o(ir_lsb), .path_o(path), .id_load_o(id_load)
  );

  jlr_dr #(.SEL_W(SEL_W), .ID_W(ID_W)) u_dr (
    .tck_i(tck_i), .rst_ni(rst_ni), .tdi_i(tdi_i), .state_i(state),
    .path_i(path), .id_load_i(id_load), .idn_i(idn_i),
    .dr_lsb_o(dr_lsb), .sel_o(sel_o)
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
      tdo_q <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  // R10
  oe_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    oe_q |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

// File: tb/jlr_top_test.sv
module jlr_top_test;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [3:0] idn = 4'h0;
  logic       tdo, tdo_oe;
  logic [7:0] sel;
  int n_run = 0, n_fail = 0;

  jlr_top uut (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .idn_i(idn),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe), .sel_o(sel)
  );

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive, sample tdo before the rising edge, return after falling edge
  task automatic step(input logic m, input logic d, output logic q);
    tms = m; tdi = d; q = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_bits(input int n, input logic [15:0] din, output logic [15:0] dout,
                            output bit oe_ok, input bit hold_chk, input logic [7:0] hold_exp,
                            output bit hold_ok);
    logic b;
    dout = '0; oe_ok = 1; hold_ok = 1;
    for (int i = 0; i < n; i++) begin
      if (!tdo_oe) oe_ok = 0;
      if (hold_chk && sel !== hold_exp) hold_ok = 0;
      step(i == n - 1, din[i], b);
      dout[i] = b;
    end
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
    logic b; logic [15:0] o; bit ok1, ok2;
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    shift_bits(8, {8'h0, op}, o, ok1, 0, 8'h0, ok2);
    cap = o[7:0];
    step(1, 0, b); step(0, 0, b);
  endtask

  task automatic scan_dr(input int n, input logic [15:0] din, output logic [15:0] dout,
                         input bit hold_chk, input logic [7:0] hold_exp, output bit hold_ok);
    logic b; bit ok1;
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    shift_bits(n, din, dout, ok1, hold_chk, hold_exp, hold_ok);
    if (hold_chk && sel !== hold_exp) hold_ok = 0;
    step(1, 0, b); step(0, 0, b);
  endtask

  task automatic do_reset();
    logic b;
    rst_n = 0; tms = 1;
    repeat (3) @(negedge tck);
    #1;
    chk(sel === 8'h00 && tdo_oe === 1'b0, "R9 reset state", {7'h0, tdo_oe, sel}, 16'h0);
    rst_n = 1;
    step(0, 0, b);
  endtask

  task automatic t_ir_capture();
    logic [7:0] c; logic b; logic [15:0] o; bit ok1, ok2;
    chk(tdo_oe === 1'b0, "R10 idle high-z", {15'h0, tdo_oe}, 16'h0);
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    shift_bits(8, 16'h00FF, o, ok1, 0, 8'h0, ok2);
    chk(o[7:0] === 8'h01, "R2 IR capture", o, 16'h0001);
    chk(ok1, "R10 oe in Shift-IR", {15'h0, ok1}, 16'h1);
    step(1, 0, b); step(0, 0, b);
    chk(tdo_oe === 1'b0, "R10 oe off after shift", {15'h0, tdo_oe}, 16'h0);
    scan_ir(8'hA5, c);
    chk(c === 8'h01, "R2 second capture", {8'h0, c}, 16'h0001);
  endtask

  task automatic t_bypass_after_reset();
    logic [15:0] o; bit hk;
    scan_dr(6, 16'h002D, o, 0, 8'h0, hk);
    chk(o[5:0] === 6'b011010, "R3 bypass from reset", o, 16'h001A);
  endtask

  task automatic t_bypass_unknown();
    logic [7:0] c; logic [15:0] o; bit hk;
    scan_ir(8'h7F, c);
    scan_dr(5, 16'h0013, o, 0, 8'h0, hk);
    chk(o[4:0] === 5'b00110, "R3 unknown opcode bypass", o, 16'h0006);
  endtask

  task automatic t_id_preload();
    logic [7:0] c; logic [15:0] o; bit hk;
    idn = 4'hA;
    scan_ir(8'hFC, c);
    scan_dr(4, 16'h0003, o, 0, 8'h0, hk);
    chk(o[3:0] === 4'hA, "R4 id preload", o, 16'h000A);
    idn = 4'h6;
    scan_dr(4, 16'h0000, o, 0, 8'h0, hk);
    chk(o[3:0] === 4'h6, "R4 id preload new pins", o, 16'h0006);
  endtask

  task automatic t_id_keep();
    logic [7:0] c; logic [15:0] o; bit hk;
    idn = 4'hA;
    scan_ir(8'hFC, c);
    scan_dr(4, 16'h0003, o, 0, 8'h0, hk);
    scan_ir(8'h7D, c);
    idn = 4'h5;
    scan_dr(4, 16'h000C, o, 0, 8'h0, hk);
    chk(o[3:0] === 4'h3, "R5 id keep old shift", o, 16'h0003);
    scan_dr(4, 16'h0000, o, 0, 8'h0, hk);
    chk(o[3:0] === 4'hC, "R5 id keep second", o, 16'h000C);
  endtask

  task automatic t_select();
    logic [7:0] c; logic [15:0] o; bit hk;
    scan_ir(8'h7E, c);
    chk(sel === 8'h00, "R11 op change leaves sel", {8'h0, sel}, 16'h0);
    scan_dr(8, 16'h005A, o, 1, 8'h00, hk);
    chk(hk, "R7 sel steady during shift", {8'h0, sel}, 16'h0);
    chk(sel === 8'h5A, "R6 sel applied", {8'h0, sel}, 16'h005A);
    scan_dr(8, 16'h0081, o, 1, 8'h5A, hk);
    chk(hk, "R7 sel steady second", {8'h0, sel}, 16'h005A);
    chk(o[7:0] === 8'h5A, "R6 sel readback", o, 16'h005A);
    chk(sel === 8'h81, "R6 sel second value", {8'h0, sel}, 16'h0081);
  endtask

  task automatic t_tlr_clear();
    logic [7:0] c; logic [15:0] o; bit hk; logic b;
    scan_ir(8'h7E, c);
    scan_dr(8, 16'h00F0, o, 0, 8'h0, hk);
    chk(sel === 8'hF0, "R6 sel before tlr", {8'h0, sel}, 16'h00F0);
    for (int i = 0; i < 5; i++) step(1, 0, b);
    chk(sel === 8'h00, "R8 tlr clears sel", {8'h0, sel}, 16'h0);
    step(0, 0, b);
    scan_dr(3, 16'h0005, o, 0, 8'h0, hk);
    chk(o[2:0] === 3'b010, "R8 tlr restores bypass", o, 16'h0002);
  endtask

  task automatic t_trst();
    logic [7:0] c; logic [15:0] o; bit hk; logic b;
    scan_ir(8'h7E, c);
    scan_dr(8, 16'h00C3, o, 0, 8'h0, hk);
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    chk(tdo_oe === 1'b1, "R10 oe in Shift-DR", {15'h0, tdo_oe}, 16'h1);
    #3 rst_n = 0;
    #2;
    chk(sel === 8'h00, "R9 async clear sel", {8'h0, sel}, 16'h0);
    chk(tdo_oe === 1'b0, "R9 async clear oe", {15'h0, tdo_oe}, 16'h0);
    @(negedge tck); #1 rst_n = 1;
    step(0, 0, b);
    scan_dr(2, 16'h0001, o, 0, 8'h0, hk);
    chk(o[1:0] === 2'b10, "R1 trst to tlr then bypass", o, 16'h0002);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge tck); #1;
    do_reset();
    t_ir_capture();
    t_bypass_after_reset();
    t_bypass_unknown();
    t_id_preload();
    t_id_keep();
    t_select();
    t_tlr_clear();
    t_trst();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule